// File: doc/BRIEF.md
# NAND Flash Host Register Front-End

This block sits between a simple processor register bus and an 8-bit NAND flash device. Software writes command bytes, address bytes, data bytes and read requests into registers. All four kinds go through one shared write buffer. A pin sequencer drains the buffer one entry at a time. For each entry it drives the latch-enable lines, the data bus and a write or read strobe, and the strobe width is set by a register field. A read is started by writing any value to the read-request register. The captured byte then appears in a read-data register and a sticky ready flag is raised. Software clears that flag by writing a one to it.

The block also keeps several pieces of state:
- A status word with the device ready line, the buffer full and empty flags, and the page-pending bits.
- A sticky event word with a masked interrupt output.
- A self-clearing reset for the page transfer counter.
- Page start bits. Each raises a pending flag that drops once a whole page of data bytes (256 or 512, chosen in the control register) has moved across the pins.

Top module: `nfc_host_front`

## Requirements
- R1: The control register (offset 0) holds the read-strobe delay in bits 3:0, the write-strobe delay in bits 7:4, the bus-width flag in bit 8 and the page-size select (0 = 256, 1 = 512 bytes) in bit 9. It reads back exactly what was written, and bits 15:10 read as zero.
- R2: While reset is asserted:
  - the status word (offset 1) reads 0x0010, showing only the buffer-empty flag;
  - all strobes are high, both latch enables are low, the data bus is not driven, and the interrupt output is low.
- R3: Writing offset 4 queues a command byte and offset 5 queues an address byte. Each is sent with the command latch or the address latch high. The write strobe is low for (write delay + 1) cycles, and the byte stays on the bus through the strobe and one cycle after it. Offset 6 queues a data byte in the same way with both latches low.
- R4: Status bit1 is high when the four-entry write buffer holds four entries, and status bit4 is high when it holds none. Event bit2 is set in the cycle after the buffer becomes empty.
- R5: A write to offsets 4 to 7 while the buffer is full is dropped and sets event bit1.
- R6: Writing any value to offset 7 queues a read. The read strobe is low for (read delay + 1) cycles, and the bus value is sampled in the last strobe cycle. That value is presented at offset 8 and sets event bit3.
- R7: Event bits (offset 2) stay set until a one is written to their position. Writing a zero has no effect.
- R8: The ready/busy input passes through a two-flop synchronizer into status bit0. A rising edge of the synchronized value sets event bit0.
- R9: Writing 1 to bit0 of offset 9 clears the page counter and both page-pending bits. Bit0 of offset 9 reads 1 for four cycles and then clears itself.
- R10: Writing bit1 of offset 10 sets status bit2. The bit clears, and event bit4 is set, when the page-size count of data bytes has been strobed out.
- R11: Writing bit0 of offset 10 sets status bit3. The bit clears when the page-size count of reads has completed.
- R12: The interrupt output is the OR of the event bits ANDed with the mask register (offset 3). The mask resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Masked interrupt |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus driven value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus sampled value |
| nand_rb | input | 1 | Device ready (high) / busy (low) |

## Verification
The stimulus covers four kinds of traffic, each checked against a behavioural model on every clock:
- **Single command and address bytes, sent with idle gaps.** These isolate strobe width and latch polarity.
- **A back-to-back burst of six data writes.** This fills the buffer and separates drop-on-full from silent queuing. The count of data strobes on the pins must be five, not six.
- **Single and streamed read requests.** These show that the sampled byte, the sticky flag and its write-one clear behave independently.
- **Full 512-byte page writes and 256-byte page reads, plus an interrupted page followed by a counter reset.** These check that the pending bit drops on exactly the last byte and not one early.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
// Shared types and register offsets for the NAND host front-end.
// Assumes a 4-bit register offset and 8-bit device bus.
package nfc_pkg;
    typedef enum logic [1:0] {K_CMD = 2'd0, K_ADDR = 2'd1, K_DATA = 2'd2, K_READ = 2'd3} ent_kind_e;

    typedef struct packed {
        ent_kind_e  kind;
        logic [7:0] val;
    } wb_ent_t;

    localparam logic [3:0] RA_CTRL  = 4'd0;
    localparam logic [3:0] RA_STAT  = 4'd1;
    localparam logic [3:0] RA_EVT   = 4'd2;
    localparam logic [3:0] RA_MASK  = 4'd3;
    localparam logic [3:0] RA_CMD   = 4'd4;
    localparam logic [3:0] RA_ADDR  = 4'd5;
    localparam logic [3:0] RA_WDATA = 4'd6;
    localparam logic [3:0] RA_RDREQ = 4'd7;
    localparam logic [3:0] RA_RDATA = 4'd8;
    localparam logic [3:0] RA_ECCR  = 4'd9;
    localparam logic [3:0] RA_PAGE  = 4'd10;

    localparam int EV_NB   = 0;
    localparam int EV_OVF  = 1;
    localparam int EV_EDGE = 2;
    localparam int EV_RDY  = 3;
    localparam int EV_WDN  = 4;
    localparam int EV_W    = 5;
endpackage

// File: rtl/nfc_wbuf.sv
`timescale 1ns/1ps
// Write buffer shared by command, address, data and read-request entries.
// Assumes: a push while full is dropped by this module (caller flags it);
// a pop while empty is ignored.
module nfc_wbuf
    import nfc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  wb_ent_t din,
    input  logic    pop,
    output wb_ent_t dout,
    output logic    full,
    output logic    empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    wb_ent_t         mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    // Store accepted entries.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full); // R4
    AST_EMPTY_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty); // R4
endmodule

// File: rtl/nfc_pinseq.sv
`timescale 1ns/1ps
// Device pin sequencer: takes one buffer entry when idle, holds the latch
// enables and bus for the strobe plus one hold cycle, strobe low for delay+1.
// Assumes the entry at the buffer head is stable while valid.
module nfc_pinseq
    import nfc_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_valid,
    input  wb_ent_t          ent_in,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic [DLY_W-1:0] wr_dly,
    output logic             ent_pop,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       dq_out,
    output logic             dq_oe,
    input  logic [7:0]       dq_in,
    output logic             xfer_done,
    output ent_kind_e        xfer_kind,
    output logic             cap_valid,
    output logic [7:0]       cap_byte
);
    typedef enum logic [1:0] {S_IDLE, S_STRB, S_HOLD} seq_st_e;

    seq_st_e          st;
    wb_ent_t          cur;
    logic [DLY_W-1:0] cnt;
    logic             busy;

    assign busy      = (st != S_IDLE);
    assign ent_pop   = (st == S_IDLE) && ent_valid;
    assign xfer_done = (st == S_STRB) && (cnt == '0);
    assign xfer_kind = cur.kind;
    assign cap_valid = xfer_done && (cur.kind == K_READ);
    assign we_n      = !((st == S_STRB) && (cur.kind != K_READ));
    assign re_n      = !((st == S_STRB) && (cur.kind == K_READ));
    assign cle       = busy && (cur.kind == K_CMD);
    assign ale       = busy && (cur.kind == K_ADDR);
    assign dq_oe     = busy && (cur.kind != K_READ);
    assign dq_out    = cur.val;

    // Step idle -> strobe -> hold, loading delay and capturing read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cur      <= '0;
            cnt      <= '0;
            cap_byte <= '0;
        end else begin
            case (st)
                S_IDLE: if (ent_valid) begin
                    cur <= ent_in;
                    cnt <= (ent_in.kind == K_READ) ? rd_dly : wr_dly;
                    st  <= S_STRB;
                end
                S_STRB: if (cnt == '0) begin
                    st <= S_HOLD;
                    if (cur.kind == K_READ) cap_byte <= dq_in;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STRB) |=> $stable(dq_out)); // R3
    AST_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STRB) |=> $stable(cle) && $stable(ale)); // R3
endmodule

// File: rtl/nfc_pagectl.sv
`timescale 1ns/1ps
// Page transfer tracking and self-clearing counter reset.
// Assumes one transfer completion per cycle at most.
module nfc_pagectl
    import nfc_pkg::*;
#(
    parameter int PG_SMALL   = 256,
    parameter int PG_LARGE   = 512,
    parameter int RST_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ecc_req,
    input  logic      pg_wr,
    input  logic [1:0] pg_bits,
    input  logic      pg_large,
    input  logic      xfer_done,
    input  ent_kind_e xfer_kind,
    output logic      rst_busy,
    output logic      rd_pend,
    output logic      wr_pend,
    output logic      wr_done
);
    localparam int PCW = $clog2(PG_LARGE);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    logic [PCW-1:0] pg_cnt, pg_last;
    logic [RCW-1:0] rst_cnt;
    logic           counted;

    assign rst_busy = (rst_cnt != '0);
    assign pg_last  = pg_large ? PCW'(PG_LARGE - 1) : PCW'(PG_SMALL - 1);
    assign counted  = xfer_done && ((wr_pend && xfer_kind == K_DATA) ||
                                    (rd_pend && xfer_kind == K_READ));
    assign wr_done  = !rst_busy && !pg_wr && counted && (pg_cnt == pg_last) &&
                      (xfer_kind == K_DATA);

    // Self-clearing reset timer.
    always_ff @(posedge clk) begin
        if (!rst_n)          rst_cnt <= '0;
        else if (ecc_req)    rst_cnt <= RCW'(RST_CYCLES);
        else if (rst_busy)   rst_cnt <= rst_cnt - 1'b1;
    end

    // Page pending flags and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_busy) begin
            pg_cnt  <= '0;
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else if (pg_wr) begin
            if (pg_bits[0]) rd_pend <= 1'b1;
            if (pg_bits[1]) wr_pend <= 1'b1;
            pg_cnt <= '0;
        end else if (counted) begin
            if (pg_cnt == pg_last) begin
                pg_cnt <= '0;
                if (xfer_kind == K_DATA) wr_pend <= 1'b0;
                else                     rd_pend <= 1'b0;
            end else begin
                pg_cnt <= pg_cnt + 1'b1;
            end
        end
    end

    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |=> (!rd_pend && !wr_pend)); // R9
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_pend); // R10
endmodule

// File: rtl/nfc_host_front.sv
`timescale 1ns/1ps
// Register front-end for an 8-bit NAND device: decodes register writes into
// buffer entries, holds control/mask/event state, synchronizes ready/busy.
// Assumes one register access per cycle, reads are combinational.
module nfc_host_front
    import nfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DLY_W      = 4,
    parameter int SYNC_N     = 2,
    parameter int RST_CYCLES = 4,
    parameter int PG_SMALL   = 256,
    parameter int PG_LARGE   = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq_o,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rb
);
    localparam int CTL_W  = 2 * DLY_W + 2;
    localparam int CTL_PG = 2 * DLY_W + 1;

    logic [CTL_W-1:0] ctrl_q;
    logic [EV_W-1:0]  evt_q, evt_set, evt_clr, mask_q;
    logic [SYNC_N-1:0] rb_sync;
    logic             wb_push, wb_full, wb_empty, wb_pop, empty_q;
    wb_ent_t          wb_in, wb_out;
    logic             xfer_done, cap_valid, rst_busy, rd_pend, wr_pend, wr_done;
    ent_kind_e        xfer_kind;
    logic [7:0]       cap_byte;
    logic             nb, wdata_unused;

    assign wdata_unused = ^reg_wdata[15:CTL_W];
    assign wb_push    = reg_wr && (reg_addr >= RA_CMD) && (reg_addr <= RA_RDREQ);
    assign wb_in.kind = ent_kind_e'(reg_addr[1:0]);
    assign wb_in.val  = reg_wdata[7:0];
    assign nb         = rb_sync[SYNC_N-1];

    nfc_wbuf #(.DEPTH(FIFO_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(wb_push), .din(wb_in), .pop(wb_pop),
        .dout(wb_out), .full(wb_full), .empty(wb_empty)
    );

    nfc_pinseq #(.DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ent_valid(!wb_empty), .ent_in(wb_out),
        .rd_dly(ctrl_q[DLY_W-1:0]), .wr_dly(ctrl_q[2*DLY_W-1:DLY_W]),
        .ent_pop(wb_pop), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
        .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
        .dq_in(nand_dq_in), .xfer_done(xfer_done), .xfer_kind(xfer_kind),
        .cap_valid(cap_valid), .cap_byte(cap_byte)
    );

    nfc_pagectl #(.PG_SMALL(PG_SMALL), .PG_LARGE(PG_LARGE), .RST_CYCLES(RST_CYCLES)) u_page (
        .clk(clk), .rst_n(rst_n),
        .ecc_req(reg_wr && reg_addr == RA_ECCR && reg_wdata[0]),
        .pg_wr(reg_wr && reg_addr == RA_PAGE), .pg_bits(reg_wdata[1:0]),
        .pg_large(ctrl_q[CTL_PG]), .xfer_done(xfer_done), .xfer_kind(xfer_kind),
        .rst_busy(rst_busy), .rd_pend(rd_pend), .wr_pend(wr_pend), .wr_done(wr_done)
    );

    // Ready/busy synchronizer chain.
    generate
        for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)      rb_sync[g] <= 1'b0;
                else if (g == 0) rb_sync[g] <= nand_rb;
                else             rb_sync[g] <= rb_sync[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    // Collect event sources and write-one-to-clear requests.
    always_comb begin
        evt_set          = '0;
        evt_set[EV_NB]   = rb_sync[SYNC_N-2] && !nb;
        evt_set[EV_OVF]  = wb_push && wb_full;
        evt_set[EV_EDGE] = wb_empty && !empty_q;
        evt_set[EV_RDY]  = cap_valid;
        evt_set[EV_WDN]  = wr_done;
        evt_clr = (reg_wr && reg_addr == RA_EVT) ? reg_wdata[EV_W-1:0] : '0;
    end

    // Control, mask and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            evt_q   <= '0;
            empty_q <= 1'b1;
        end else begin
            if (reg_wr && reg_addr == RA_CTRL) ctrl_q <= reg_wdata[CTL_W-1:0];
            if (reg_wr && reg_addr == RA_MASK) mask_q <= reg_wdata[EV_W-1:0];
            evt_q   <= (evt_q & ~evt_clr) | evt_set;
            empty_q <= wb_empty;
        end
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = 16'(ctrl_q);
            RA_STAT:  reg_rdata = 16'({wb_empty, rd_pend, wr_pend, wb_full, nb});
            RA_EVT:   reg_rdata = 16'(evt_q);
            RA_MASK:  reg_rdata = 16'(mask_q);
            RA_RDATA: reg_rdata = 16'(cap_byte);
            RA_ECCR:  reg_rdata = 16'(rst_busy);
            default:  reg_rdata = 16'h0000;
        endcase
    end

    assign irq_o = |(evt_q & mask_q);

    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_push && wb_full) |=> evt_q[EV_OVF]); // R5
    AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[EV_RDY] && !(reg_wr && reg_addr == RA_EVT && reg_wdata[EV_RDY])) |=> evt_q[EV_RDY]); // R7
    AST_NB_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nb) |-> evt_q[EV_NB]); // R8
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> evt_q[EV_RDY]); // R6
endmodule

// File: tb/test_nfc_host_front.sv
`timescale 1ns/1ps
module test_nfc_host_front;
    logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, rb = 1'b1;
    logic [3:0]  reg_addr = 4'd1;
    logic [15:0] reg_wdata = '0;
    logic [7:0]  dq_in = 8'h00;
    wire  [15:0] reg_rdata;
    wire         irq_o, cle, ale, we_n, re_n, dq_oe;
    wire  [7:0]  dq_out;

    always #2 clk = ~clk;

    nfc_host_front i_nfc_host_front (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in), .nand_rb(rb)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int mq[$];
    int m_ph, m_left, m_kind, m_byte, m_rdat, m_irq, m_mask, m_ctrl, m_rstc, m_pgc;
    bit m_prev_empty = 1, m_rdp, m_wrp, m_s1, m_s2;

    always @(posedge clk) begin
        int v, set, clr, xk, psz;
        bit was_full, was_empty, xfer;
        if (!rst_n) begin
            mq.delete(); m_ph = 0; m_left = 0; m_kind = 0; m_byte = 0; m_rdat = 0;
            m_irq = 0; m_mask = 0; m_ctrl = 0; m_rstc = 0; m_pgc = 0;
            m_prev_empty = 1; m_rdp = 0; m_wrp = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            set = 0; clr = 0; xfer = 0; xk = 0;
            was_full  = (mq.size() == 4);
            was_empty = (mq.size() == 0);
            psz = ((m_ctrl >> 9) & 1) ? 512 : 256;
            if (m_s1 && !m_s2) set |= 1;
            m_s2 = m_s1; m_s1 = rb;
            if (was_empty && !m_prev_empty) set |= 4;
            m_prev_empty = was_empty;
            case (m_ph)
                0: if (!was_empty) begin
                    v = mq.pop_front(); m_kind = v >> 8; m_byte = v & 255; m_ph = 1;
                    m_left = (m_kind == 3) ? (m_ctrl & 15) : ((m_ctrl >> 4) & 15);
                end
                1: if (m_left == 0) begin
                    m_ph = 2; xfer = 1; xk = m_kind;
                    if (m_kind == 3) begin m_rdat = dq_in; set |= 8; end
                end else m_left--;
                default: m_ph = 0;
            endcase
            if (m_rstc != 0) begin
                m_rdp = 0; m_wrp = 0; m_pgc = 0;
            end else if (reg_wr && reg_addr == 10) begin
                if (reg_wdata[0]) m_rdp = 1;
                if (reg_wdata[1]) m_wrp = 1;
                m_pgc = 0;
            end else if (xfer && ((m_wrp && xk == 2) || (m_rdp && xk == 3))) begin
                if (m_pgc == psz - 1) begin
                    m_pgc = 0;
                    if (xk == 2) begin m_wrp = 0; set |= 16; end else m_rdp = 0;
                end else m_pgc++;
            end
            if (reg_wr && reg_addr == 9 && reg_wdata[0]) m_rstc = 4;
            else if (m_rstc != 0) m_rstc--;
            if (reg_wr) begin
                case (reg_addr)
                    4'd0: m_ctrl = reg_wdata & 16'h03ff;
                    4'd2: clr = reg_wdata & 31;
                    4'd3: m_mask = reg_wdata & 31;
                    4'd4, 4'd5, 4'd6, 4'd7:
                        if (was_full) set |= 2;
                        else mq.push_back(((reg_addr - 4) << 8) | reg_wdata[7:0]);
                    default: ;
                endcase
            end
            m_irq = (m_irq & ~clr) | set;
        end
    end

    // Per-cycle comparison against the model and independent pin observers.
    int we_run = 0, re_run = 0, we_width = 0, re_width = 0, data_strobes = 0;
    int cle_byte = 0, ale_byte = 0;
    bit prev_we = 1, prev_re = 1;
    always @(negedge clk) begin
        int e, a;
        if (cmp_on) begin
            e = {(m_ph == 1 && m_kind != 3) ? 1'b0 : 1'b1, (m_ph == 1 && m_kind == 3) ? 1'b0 : 1'b1,
                 m_ph != 0 && m_kind == 0, m_ph != 0 && m_kind == 1, m_ph != 0 && m_kind != 3};
            a = {we_n, re_n, cle, ale, dq_oe};
            chk(a == e, "R3 pin state", a, e);
            if (dq_oe) chk(dq_out == m_byte, "R3 bus byte", dq_out, m_byte);
            chk(irq_o == ((m_irq & m_mask) != 0), "R12 irq out", irq_o, (m_irq & m_mask) != 0);
            if (!reg_wr && reg_addr == 4'd1) begin
                e = {mq.size() == 0, m_rdp, m_wrp, mq.size() == 4, m_s2};
                chk(reg_rdata == e, "R4 status word", reg_rdata, e);
            end
        end
        if (!we_n) we_run++; else if (!prev_we) begin we_width = we_run; we_run = 0; end
        if (!re_n) re_run++; else if (!prev_re) begin re_width = re_run; re_run = 0; end
        if (!we_n && prev_we && !cle && !ale) data_strobes++;
        if (!we_n && cle) cle_byte = dq_out;
        if (!we_n && ale) ale_byte = dq_out;
        prev_we = we_n; prev_re = re_n;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 4'd1;
    endtask

    task automatic fill(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        while (mq.size() >= 4) begin @(posedge clk); #1; end
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 4'd1;
    endtask

    task automatic burst(input logic [3:0] a, input int n);
        @(posedge clk); #1;
        for (int i = 0; i < n; i++) begin
            reg_wr = 1'b1; reg_addr = a; reg_wdata = 16'(8'h30 + i);
            @(posedge clk); #1;
        end
        reg_wr = 1'b0; reg_addr = 4'd1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (!(mq.size() == 0 && m_ph == 0));
        #1;
    endtask

    initial begin
        logic [15:0] d;
        int ds;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(reg_rdata == 16'h0010, "R2 reset status", reg_rdata, 16'h0010);
        chk(we_n && re_n && !cle && !ale && !dq_oe, "R2 reset pins", {we_n, re_n, cle, ale, dq_oe}, 5'b11000);
        chk(irq_o == 1'b0, "R2 reset irq", irq_o, 0);
        @(posedge clk); #1; rst_n = 1'b1; cmp_on = 1;
        rd(4'd3, d); chk(d == 0, "R12 mask reset", d, 0);

        wr(4'd0, 16'h0321); rd(4'd0, d); chk(d == 16'h0321, "R1 ctrl readback", d, 16'h0321);
        wr(4'd0, 16'hffff); rd(4'd0, d); chk(d == 16'h03ff, "R1 upper bits zero", d, 16'h03ff);
        wr(4'd0, 16'h0021);

        wr(4'd4, 16'h0090); wait_idle();
        chk(cle_byte == 8'h90, "R3 command byte", cle_byte, 8'h90);
        chk(we_width == 3, "R3 write strobe width", we_width, 3);
        wr(4'd5, 16'h00c3); wait_idle();
        chk(ale_byte == 8'hc3, "R3 address byte", ale_byte, 8'hc3);

        wr(4'd2, 16'h001f);
        ds = data_strobes;
        burst(4'd6, 6);
        rd(4'd2, d); chk(d[1] == 1'b1, "R5 overflow flag", d[1], 1);
        wait_idle(); @(posedge clk); #1;
        chk(data_strobes - ds == 5, "R5 dropped entry", data_strobes - ds, 5);
        rd(4'd2, d); chk(d[2] == 1'b1, "R4 empty edge event", d[2], 1);

        wr(4'd2, 16'h001f);
        dq_in = 8'h5a;
        wr(4'd7, 16'h1234);
        while ((m_irq & 8) == 0) @(posedge clk);
        rd(4'd8, d); chk(d == 16'h005a, "R6 read data", d, 16'h005a);
        chk(re_width == 2, "R6 read strobe width", re_width, 2);
        repeat (5) @(posedge clk);
        rd(4'd2, d); chk(d[3] == 1'b1, "R7 ready sticky", d[3], 1);
        wr(4'd2, 16'h0000); rd(4'd2, d); chk(d[3] == 1'b1, "R7 zero write ignored", d[3], 1);
        wr(4'd2, 16'h0008); rd(4'd2, d); chk(d[3] == 1'b0, "R7 one clears", d[3], 0);

        wr(4'd2, 16'h001f);
        rb = 1'b0; repeat (4) @(posedge clk);
        rd(4'd1, d); chk(d[0] == 1'b0, "R8 busy seen", d[0], 0);
        rd(4'd2, d); chk(d[0] == 1'b0, "R8 no event on fall", d[0], 0);
        @(posedge clk); #1; rb = 1'b1;
        repeat (3) @(posedge clk);
        rd(4'd1, d); chk(d[0] == 1'b1, "R8 ready seen", d[0], 1);
        rd(4'd2, d); chk(d[0] == 1'b1, "R8 ready event", d[0], 1);

        @(negedge clk); chk(irq_o == 1'b0, "R12 masked off", irq_o, 0);
        wr(4'd3, 16'h0001);
        @(negedge clk); chk(irq_o == 1'b1, "R12 unmasked", irq_o, 1);
        wr(4'd2, 16'h0001);
        @(negedge clk); chk(irq_o == 1'b0, "R12 cleared", irq_o, 0);

        wr(4'd10, 16'h0002);
        for (int i = 0; i < 3; i++) fill(4'd6, 16'(i));
        wr(4'd9, 16'h0001);
        rd(4'd9, d); chk(d[0] == 1'b1, "R9 reset busy", d[0], 1);
        repeat (6) @(posedge clk);
        rd(4'd9, d); chk(d[0] == 1'b0, "R9 reset self-clear", d[0], 0);
        rd(4'd1, d); chk(d[2] == 1'b0, "R9 pending cleared", d[2], 0);
        wait_idle();

        wr(4'd0, 16'h0221); wr(4'd2, 16'h001f);
        wr(4'd10, 16'h0002);
        rd(4'd1, d); chk(d[2] == 1'b1, "R10 write pending", d[2], 1);
        for (int i = 0; i < 511; i++) fill(4'd6, 16'(i));
        wait_idle();
        rd(4'd1, d); chk(d[2] == 1'b1, "R10 pending before last", d[2], 1);
        fill(4'd6, 16'h00ee); wait_idle();
        rd(4'd1, d); chk(d[2] == 1'b0, "R10 pending cleared", d[2], 0);
        rd(4'd2, d); chk(d[4] == 1'b1, "R10 done event", d[4], 1);

        wr(4'd0, 16'h0021);
        wr(4'd10, 16'h0001);
        rd(4'd1, d); chk(d[3] == 1'b1, "R11 read pending", d[3], 1);
        dq_in = 8'h3c;
        for (int i = 0; i < 255; i++) fill(4'd7, 16'h0000);
        wait_idle();
        rd(4'd1, d); chk(d[3] == 1'b1, "R11 pending before last", d[3], 1);
        fill(4'd7, 16'h0000); wait_idle();
        rd(4'd1, d); chk(d[3] == 1'b0, "R11 pending cleared", d[3], 0);
        rd(4'd8, d); chk(d == 16'h003c, "R6 streamed read data", d, 16'h003c);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule